// File: doc/BRIEF.md
# Wide Operand Fetch and Pack Unit

This unit fetches one instruction operand for a datapath whose memory is organised as 16-bit locations with 32-bit addresses. A command carries a base address, an index value, a flag that forces the index to contribute nothing, and a two-bit width code. The unit forms the effective address. It then reads one location, or two consecutive locations, through a request/response memory port. It returns the operand right-aligned in a 32-bit word and raises a one-cycle completion strobe.

A 32-bit operand is built from two locations. The low bytes of both locations form the lower half of the result and the high bytes form the upper half. The first location always supplies the less significant byte of each pair. With this arrangement, a pair of locations whose upper bytes are zero reads back as an ordinary little-endian 16-bit quantity.

The command port is a valid/ready stream. A command is taken on a cycle where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` stays low from acceptance until the completion strobe has been shown, so only one fetch is ever in flight. The read-request port is also valid/ready. Once raised, `rd_valid` stays high with a stable address until `rd_ready` accepts it. The response side has no back-pressure. `rsp_valid` is looked at only while a read is outstanding.

Top module: `opnd_fetch_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `cmd_ready` is 1, `rd_valid` is 0, `done` is 0 and `operand` is 0.
- R2: The address of the first read is `cmd_base + cmd_index` modulo 2^32. When `cmd_idx_zero` is 1 it is `cmd_base` alone.
- R3: Width code 00 (8-bit) issues exactly one read, and `operand` is the low byte of that location zero-extended to 32 bits.
- R4: Width code 01 (16-bit) issues exactly one read, and `operand` is the whole location zero-extended to 32 bits.
- R5: Width codes 10 and 11 (32-bit) issue two reads, the second at the first address plus one modulo 2^32. With first word F and second word S, `operand` bits 7:0 = F[7:0], 15:8 = S[7:0], 23:16 = F[15:8] and 31:24 = S[15:8]. For example, 0xAABB then 0xCCDD gives 0xCCAADDBB.
- R6: `done` is high for exactly one cycle, the cycle right after the cycle in which the last read response is valid. `operand` changes only on entry to that cycle.
- R7: `rd_valid`, once high, stays high with `rd_addr` unchanged until a cycle with `rd_ready` high. `cmd_ready` is low whenever a fetch is in progress.
- R8: For a 32-bit fetch whose two locations have zero upper bytes, `operand` equals `{16'h0, S[7:0], F[7:0]}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Fetch command present |
| cmd_ready | output | 1 | Unit idle and able to take a command |
| cmd_base | input | 32 | Base address |
| cmd_index | input | 32 | Index register value |
| cmd_idx_zero | input | 1 | Index register is the status register; index counts as zero |
| cmd_width | input | 2 | 00 = 8-bit, 01 = 16-bit, 10/11 = 32-bit |
| rd_valid | output | 1 | Read request present |
| rd_ready | input | 1 | Memory accepts the read request |
| rd_addr | output | 32 | Location address of the request |
| rsp_valid | input | 1 | Read data present |
| rsp_data | input | 16 | Read data, one location |
| done | output | 1 | One-cycle completion strobe |
| operand | output | 32 | Packed, zero-extended operand |

## Verification
The first read request appears in the cycle after the command is taken. A second read request appears in the cycle after the first response. `done` and the new `operand` appear in the cycle after the last response and drop one cycle later. The bench drives every input on the falling edge and samples on the falling edge. It checks each request address at the falling edge of its accepting cycle. It checks `done`, `operand` and the absence of further requests at the first falling edge after the last response, and the fall of `done` at the falling edge after that. Memory acceptance and response delays are random, so these windows are tested under varying stall lengths.

// File: rtl/ofu_pkg.sv
package ofu_pkg;
  typedef enum logic [1:0] {
    WID_B8  = 2'b00,
    WID_B16 = 2'b01,
    WID_B32 = 2'b10,
    WID_B32A = 2'b11
  } wid_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_LO,
    ST_WAIT_LO,
    ST_REQ_HI,
    ST_WAIT_HI,
    ST_DONE
  } seq_e;

  function automatic logic wid_is_pair(input wid_e w);
    return w[1];
  endfunction
endpackage

// File: rtl/ofu_addr_gen.sv
module ofu_addr_gen #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] index,
  input  logic              idx_zero,
  input  logic [ADDR_W-1:0] ea_held,
  output logic [ADDR_W-1:0] ea_new,
  output logic [ADDR_W-1:0] ea_step
);
  logic [ADDR_W-1:0] idx_eff;

  always_comb begin
    idx_eff = idx_zero ? '0 : index;
    ea_new  = base + idx_eff;
    ea_step = ea_held + {{(ADDR_W-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/ofu_packer.sv
module ofu_packer
  import ofu_pkg::*;
#(
  parameter int LOC_W = 16,
  localparam int HALF_W = LOC_W / 2,
  localparam int OPND_W = 2 * LOC_W
) (
  input  wid_e              wid,
  input  logic [LOC_W-1:0]  first_w,
  input  logic [LOC_W-1:0]  second_w,
  output logic [OPND_W-1:0] packed_o
);
  logic [OPND_W-1:0] pair_v;

  // Interleave: low halves form the lower half of the result, first word first.
  always_comb begin
    pair_v = {second_w[LOC_W-1:HALF_W], first_w[LOC_W-1:HALF_W],
              second_w[HALF_W-1:0],     first_w[HALF_W-1:0]};
    unique case (wid)
      WID_B8:  packed_o = {{(OPND_W-HALF_W){1'b0}}, first_w[HALF_W-1:0]};
      WID_B16: packed_o = {{(OPND_W-LOC_W){1'b0}}, first_w};
      default: packed_o = pair_v;
    endcase
  end
endmodule

// File: rtl/ofu_seq.sv
module ofu_seq
  import ofu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_fire,
  input  logic pair,
  input  logic rd_ready,
  input  logic rsp_valid,
  output logic idle,
  output logic rd_valid,
  output logic hi_phase,
  output logic cap_lo,
  output logic finish,
  output logic done
);
  seq_e st_q, st_d;

  always_comb begin
    st_d     = st_q;
    idle     = (st_q == ST_IDLE);
    rd_valid = (st_q == ST_REQ_LO) || (st_q == ST_REQ_HI);
    hi_phase = (st_q == ST_REQ_HI);
    done     = (st_q == ST_DONE);
    cap_lo   = 1'b0;
    finish   = 1'b0;
    unique case (st_q)
      ST_IDLE:    if (cmd_fire) st_d = ST_REQ_LO;
      ST_REQ_LO:  if (rd_ready) st_d = ST_WAIT_LO;
      ST_WAIT_LO: if (rsp_valid) begin
        if (pair) begin
          cap_lo = 1'b1;
          st_d   = ST_REQ_HI;
        end else begin
          finish = 1'b1;
          st_d   = ST_DONE;
        end
      end
      ST_REQ_HI:  if (rd_ready) st_d = ST_WAIT_HI;
      ST_WAIT_HI: if (rsp_valid) begin
        finish = 1'b1;
        st_d   = ST_DONE;
      end
      ST_DONE:    st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/opnd_fetch_unit.sv
module opnd_fetch_unit
  import ofu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LOC_W  = 16,
  localparam int OPND_W = 2 * LOC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_base,
  input  logic [ADDR_W-1:0] cmd_index,
  input  logic              cmd_idx_zero,
  input  logic [1:0]        cmd_width,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rsp_valid,
  input  logic [LOC_W-1:0]  rsp_data,
  output logic              done,
  output logic [OPND_W-1:0] operand
);
  logic              cmd_fire, idle, hi_phase, cap_lo, finish;
  logic [ADDR_W-1:0] ea_q, ea_new, ea_step;
  wid_e              wid_q;
  logic [LOC_W-1:0]  lo_q, pk_first;
  logic [OPND_W-1:0] pk_out, opnd_q;

  assign cmd_ready = idle;
  assign cmd_fire  = cmd_valid && idle;

  ofu_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .base(cmd_base), .index(cmd_index), .idx_zero(cmd_idx_zero),
    .ea_held(ea_q), .ea_new(ea_new), .ea_step(ea_step)
  );

  ofu_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_fire(cmd_fire), .pair(wid_is_pair(wid_q)),
    .rd_ready(rd_ready), .rsp_valid(rsp_valid), .idle(idle),
    .rd_valid(rd_valid), .hi_phase(hi_phase), .cap_lo(cap_lo),
    .finish(finish), .done(done)
  );

  assign pk_first = wid_is_pair(wid_q) ? lo_q : rsp_data;

  ofu_packer #(.LOC_W(LOC_W)) u_pack (
    .wid(wid_q), .first_w(pk_first), .second_w(rsp_data), .packed_o(pk_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ea_q   <= '0;
      wid_q  <= WID_B8;
      lo_q   <= '0;
      opnd_q <= '0;
    end else begin
      if (cmd_fire) begin
        ea_q  <= ea_new;
        wid_q <= wid_e'(cmd_width);
      end
      if (cap_lo) lo_q   <= rsp_data;
      if (finish) opnd_q <= pk_out;
    end
  end

  assign rd_addr = hi_phase ? ea_step : ea_q;
  assign operand = opnd_q;
endmodule

// File: rtl/ofu_fetch_chk.sv
module ofu_fetch_chk #(
  parameter int ADDR_W = 32,
  parameter int OPND_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rsp_valid,
  input logic              done,
  input logic [OPND_W-1:0] operand
);
  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  // R7
  busy_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !cmd_ready);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(rsp_valid));

  // R6
  opnd_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(operand));
endmodule

bind opnd_fetch_unit ofu_fetch_chk #(.ADDR_W(ADDR_W), .OPND_W(OPND_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_addr(rd_addr), .rsp_valid(rsp_valid),
  .done(done), .operand(operand)
);

// File: tb/sim_opnd_fetch_unit.sv
`timescale 1ns/1ps
module sim_opnd_fetch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_base = '0, cmd_index = '0;
  logic        cmd_idx_zero = 1'b0;
  logic [1:0]  cmd_width = '0;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [31:0] rd_addr;
  logic        rsp_valid = 1'b0;
  logic [15:0] rsp_data = '0;
  logic        done;
  logic [31:0] operand;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  opnd_fetch_unit u0 (.*);

  function automatic logic [31:0] exp_opnd(input logic [1:0] w,
                                           input logic [15:0] f,
                                           input logic [15:0] s);
    if (w == 2'b00) return {24'h0, f[7:0]};
    if (w == 2'b01) return {16'h0, f};
    return {s[15:8], f[15:8], s[7:0], f[7:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_fetch(input logic [31:0] base, input logic [31:0] idx,
                           input logic iz, input logic [1:0] w,
                           input logic [15:0] f, input logic [15:0] s,
                           input string req);
    logic [31:0] ea = iz ? base : base + idx;
    int nreads = w[1] ? 2 : 1;
    @(negedge clk);
    chk("R7 idle ready", {31'h0, cmd_ready}, 32'h1);
    cmd_valid = 1'b1; cmd_base = base; cmd_index = idx;
    cmd_idx_zero = iz; cmd_width = w;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_base = $urandom; cmd_index = $urandom;
    for (int k = 0; k < nreads; k++) begin
      forever begin
        if (rd_valid && ($urandom % 3 != 0)) break;
        if (rd_valid) chk("R7 busy", {31'h0, cmd_ready}, 32'h0);
        @(negedge clk);
      end
      chk(k == 0 ? "R2 first addr" : "R5 second addr", rd_addr,
          k == 0 ? ea : ea + 32'd1);
      rd_ready = 1'b1;
      @(negedge clk);
      rd_ready = 1'b0;
      repeat ($urandom % 3) @(negedge clk);
      rsp_valid = 1'b1; rsp_data = (k == 0) ? f : s;
      @(negedge clk);
      rsp_valid = 1'b0; rsp_data = $urandom;
    end
    chk({req, " done"}, {31'h0, done}, 32'h1);
    chk({req, " operand"}, operand, exp_opnd(w, f, s));
    chk({req, " read count"}, {31'h0, rd_valid}, 32'h0);
    @(negedge clk);
    chk("R6 done single", {31'h0, done}, 32'h0);
    chk("R6 operand held", operand, exp_opnd(w, f, s));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [1:0] w;
    void'($urandom(32'd7341));
    repeat (3) @(negedge clk);
    chk("R1 ready", {31'h0, cmd_ready}, 32'h1);
    chk("R1 rd_valid", {31'h0, rd_valid}, 32'h0);
    chk("R1 done", {31'h0, done}, 32'h0);
    chk("R1 operand", operand, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {30'h0, rd_valid, done}, 32'h0);
    // directed corners
    run_fetch(32'h0000_1000, 32'h0000_0010, 1'b0, 2'b10, 16'hAABB, 16'hCCDD, "R5 interleave");
    chk("R5 example", operand, 32'hCCAADDBB);
    run_fetch(32'h0000_2000, 32'h0000_0001, 1'b0, 2'b11, 16'h0034, 16'h0012, "R8 zero upper");
    chk("R8 little endian", operand, 32'h0000_1234);
    run_fetch(32'hFFFF_FFFF, 32'h0, 1'b0, 2'b10, 16'h1357, 16'h2468, "R5 addr wrap");
    run_fetch(32'hFFFF_FFF0, 32'h0000_0020, 1'b0, 2'b01, 16'hBEEF, 16'h0, "R2 sum wrap");
    run_fetch(32'h0000_4000, 32'hDEAD_0000, 1'b1, 2'b00, 16'hFF81, 16'h0, "R3 byte idx zero");
    run_fetch(32'h0000_5000, 32'h1, 1'b1, 2'b01, 16'h8001, 16'h0, "R4 word idx zero");
    // random mix
    for (int i = 0; i < 300; i++) begin
      w = 2'($urandom);
      run_fetch($urandom, $urandom, 1'($urandom), w, 16'($urandom), 16'($urandom),
                w == 2'b00 ? "R3 random" : (w == 2'b01 ? "R4 random" : "R5 random"));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule